// File: doc/BRIEF.md
# Parallel Byte Configuration Host Sequencer

This block is the host side of an 8-bit parallel configuration link to a programmable target. On a start request it pulls the target's reconfiguration request line low for a fixed number of system clocks. It then waits for the target's status line to come back high and lets a further settling delay run out. After that it feeds the bitstream, taken from a valid/ready byte stream, onto an 8-bit data bus while generating the configuration clock itself.

When the target decompresses or decrypts, every byte must see several configuration clock rising edges. A parameter sets that ratio: 1 for a plain bitstream, 4 for a compressed or encrypted one. When the stream runs dry the configuration clock simply stops low. The sequencer watches the target's status, done and initialization-done lines. It reports success once the target enters user mode. If status drops during loading it reports an error, and if done or initialization-done fails to arrive in time it reports a timeout. In every case it returns to idle so the caller can retry.

Top module: `pcfg_host`

## Requirements
- R1: After reset `cfg_req_n` is 1, `cfg_clk` is 0, `s_ready` is 0, and `busy`, `cfg_ok`, `err_status` and `err_timeout` are all 0.
- R2: A `start` pulse seen while idle drives `cfg_req_n` low for exactly REQ_LOW_CYC system clocks, after which it returns high. A `start` seen while `busy` is 1 has no effect on `cfg_req_n`.
- R3: No rising edge appears on `cfg_clk` until `tgt_status` has been sampled high and at least ST2CK_CYC further system clocks have passed.
- R4: Each accepted byte appears on `cfg_data` for exactly CLKS_PER_BYTE rising edges of `cfg_clk`, bytes in stream order. Each `cfg_clk` high phase lasts one system clock and is followed by at least one low clock.
- R5: `s_ready` is 1 only while `cfg_clk` is high on the last rising edge of the current byte. A byte is consumed exactly once, in that cycle.
- R6: While `s_valid` is 0 during loading, `cfg_clk` stays low and no edge is issued. A rising edge only follows a system clock in which `s_valid` was 1 with the clock low.
- R7: If `tgt_status` is low while bytes are being clocked or while waiting for done, then on the next clock `err_status` is 1, `busy` is 0 and `cfg_clk` is 0, with no further edge.
- R8: When `tgt_done` is high during loading or while waiting for it, the sequencer stops clocking and waits for `tgt_init_done`. When that arrives, `cfg_ok` becomes 1 and `busy` becomes 0.
- R9: If `tgt_done` has not risen within DONE_TMO_CYC clocks after the byte marked `s_last` was taken, or `tgt_init_done` has not risen within INIT_TMO_CYC clocks after done, `err_timeout` becomes 1 and `busy` becomes 0.
- R10: `cfg_clk` is held at 0 whenever bytes are not being clocked, including indefinitely after completion.
- R11: At most one of `cfg_ok`, `err_status` and `err_timeout` is 1 at any time. All three are cleared when a `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous-style reset, sampled synchronously |
| start | input | 1 | Begin a configuration cycle (honoured only when idle) |
| s_data | input | 8 | Bitstream byte |
| s_valid | input | 1 | `s_data` holds a byte |
| s_last | input | 1 | Marks the final byte of the bitstream |
| s_ready | output | 1 | Byte consumed in this cycle |
| tgt_status | input | 1 | Target status line, high when ready and error-free |
| tgt_done | input | 1 | Target done line, rises when loading completes |
| tgt_init_done | input | 1 | Target initialization complete, user mode entered |
| cfg_req_n | output | 1 | Active-low reconfiguration request to the target |
| cfg_clk | output | 1 | Configuration clock to the target |
| cfg_data | output | 8 | Configuration data bus to the target |
| busy | output | 1 | A configuration cycle is in progress |
| cfg_ok | output | 1 | Last cycle reached user mode |
| err_status | output | 1 | Last cycle aborted by status dropping low |
| err_timeout | output | 1 | Last cycle timed out waiting for done or init-done |

## Verification
The target's done line can rise in the same system clock as the final byte's handshake. Loading completion and byte consumption then coincide. The done transition must win, so the sequencer goes straight to waiting for initialization-done and not to the done timeout, and the byte must still count as taken exactly once. The bench provokes this by having its target model raise done at the very negative edge where the last rising configuration edge is observed. It judges the outcome by the handshake count, the edge count and a clean `cfg_ok` with no timeout flag.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT_RDY,
    ST_DELAY,
    ST_XFER,
    ST_WAIT_DONE,
    ST_WAIT_INIT
  } pcfg_state_e;

  // larger of two counts
  function automatic int unsigned f_max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // bits needed to hold the values 0 .. n-1 (at least one bit)
  function automatic int unsigned f_cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // timer preload for a wait of n cycles (counter expires at zero)
  function automatic int unsigned f_preload(input int unsigned n);
    return (n == 0) ? 0 : n - 1;
  endfunction

endpackage

// File: rtl/pcfg_timer.sv
module pcfg_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - W'(1);
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/pcfg_pacer.sv
module pcfg_pacer #(
  parameter int unsigned CPB = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,        // loading continues after this edge
  input  logic xfer_act,   // loading in progress this cycle
  input  logic s_valid,
  output logic cfg_clk,
  output logic edge_last,  // current edge is the byte's final one
  output logic s_ready
);

  logic ck_q;

  // one high clock per edge, rise only when a byte is waiting
  always_ff @(posedge clk) begin
    if (!rst_n)      ck_q <= 1'b0;
    else if (!run)   ck_q <= 1'b0;
    else if (ck_q)   ck_q <= 1'b0;
    else             ck_q <= s_valid;
  end

  generate
    if (CPB > 1) begin : g_multi
      localparam int unsigned EW = pcfg_pkg::f_cnt_w(CPB);
      localparam logic [EW-1:0] LAST = EW'(CPB - 1);
      logic [EW-1:0] ecnt_q;

      always_ff @(posedge clk) begin
        if (!rst_n)      ecnt_q <= '0;
        else if (!run)   ecnt_q <= '0;
        else if (ck_q)   ecnt_q <= (ecnt_q == LAST) ? '0 : ecnt_q + EW'(1);
      end

      assign edge_last = (ecnt_q == LAST);
    end else begin : g_single
      assign edge_last = 1'b1;
    end
  endgenerate

  assign cfg_clk = ck_q;
  assign s_ready = xfer_act & ck_q & edge_last;

endmodule

// File: rtl/pcfg_seq.sv
module pcfg_seq
  import pcfg_pkg::*;
#(
  parameter int unsigned REQ_LOW_CYC  = 8,
  parameter int unsigned ST2CK_CYC    = 10,
  parameter int unsigned DONE_TMO_CYC = 200,
  parameter int unsigned INIT_TMO_CYC = 100,
  parameter int unsigned TW           = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          tgt_status,
  input  logic          tgt_done,
  input  logic          tgt_init_done,
  input  logic          last_take,
  input  logic          tmr_expired,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          xfer_act,
  output logic          xfer_next,
  output logic          cfg_req_n,
  output logic          busy,
  output logic          cfg_ok,
  output logic          err_status,
  output logic          err_timeout
);

  pcfg_state_e state_q, state_d;
  logic set_ok, set_es, set_et, clr_flags;
  logic ok_q, es_q, et_q;

  always_comb begin
    state_d   = state_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    set_ok    = 1'b0;
    set_es    = 1'b0;
    set_et    = 1'b0;
    clr_flags = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        state_d   = ST_REQ;
        tmr_load  = 1'b1;
        tmr_val   = TW'(f_preload(REQ_LOW_CYC));
        clr_flags = 1'b1;
      end
      ST_REQ: if (tmr_expired) state_d = ST_WAIT_RDY;
      ST_WAIT_RDY: if (tgt_status) begin
        state_d  = ST_DELAY;
        tmr_load = 1'b1;
        tmr_val  = TW'(f_preload(ST2CK_CYC));
      end
      ST_DELAY: if (tmr_expired) state_d = ST_XFER;
      ST_XFER: begin
        if (!tgt_status) begin
          state_d = ST_IDLE;
          set_es  = 1'b1;
        end else if (tgt_done) begin
          state_d  = ST_WAIT_INIT;
          tmr_load = 1'b1;
          tmr_val  = TW'(f_preload(INIT_TMO_CYC));
        end else if (last_take) begin
          state_d  = ST_WAIT_DONE;
          tmr_load = 1'b1;
          tmr_val  = TW'(f_preload(DONE_TMO_CYC));
        end
      end
      ST_WAIT_DONE: begin
        if (!tgt_status) begin
          state_d = ST_IDLE;
          set_es  = 1'b1;
        end else if (tgt_done) begin
          state_d  = ST_WAIT_INIT;
          tmr_load = 1'b1;
          tmr_val  = TW'(f_preload(INIT_TMO_CYC));
        end else if (tmr_expired) begin
          state_d = ST_IDLE;
          set_et  = 1'b1;
        end
      end
      ST_WAIT_INIT: begin
        if (tgt_init_done) begin
          state_d = ST_IDLE;
          set_ok  = 1'b1;
        end else if (tmr_expired) begin
          state_d = ST_IDLE;
          set_et  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ok_q    <= 1'b0;
      es_q    <= 1'b0;
      et_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (clr_flags) begin
        ok_q <= 1'b0;
        es_q <= 1'b0;
        et_q <= 1'b0;
      end else begin
        if (set_ok) ok_q <= 1'b1;
        if (set_es) es_q <= 1'b1;
        if (set_et) et_q <= 1'b1;
      end
    end
  end

  assign xfer_act    = (state_q == ST_XFER);
  assign xfer_next   = (state_d == ST_XFER);
  assign cfg_req_n   = (state_q != ST_REQ);
  assign busy        = (state_q != ST_IDLE);
  assign cfg_ok      = ok_q;
  assign err_status  = es_q;
  assign err_timeout = et_q;

endmodule

// File: rtl/pcfg_host.sv
module pcfg_host
  import pcfg_pkg::*;
#(
  parameter int unsigned CLKS_PER_BYTE = 4,
  parameter int unsigned REQ_LOW_CYC   = 8,
  parameter int unsigned ST2CK_CYC     = 10,
  parameter int unsigned DONE_TMO_CYC  = 200,
  parameter int unsigned INIT_TMO_CYC  = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] s_data,
  input  logic       s_valid,
  input  logic       s_last,
  output logic       s_ready,
  input  logic       tgt_status,
  input  logic       tgt_done,
  input  logic       tgt_init_done,
  output logic       cfg_req_n,
  output logic       cfg_clk,
  output logic [7:0] cfg_data,
  output logic       busy,
  output logic       cfg_ok,
  output logic       err_status,
  output logic       err_timeout
);

  localparam int unsigned TMR_MAX = f_max2(f_max2(REQ_LOW_CYC, ST2CK_CYC),
                                           f_max2(DONE_TMO_CYC, INIT_TMO_CYC));
  localparam int unsigned TW = f_cnt_w(TMR_MAX);

  // internal events, named for the checker
  logic          xfer_act;
  logic          xfer_next;
  logic          edge_last;
  logic          last_take;
  logic          tmr_load;
  logic          tmr_expired;
  logic [TW-1:0] tmr_val;

  assign last_take = s_ready & s_valid & s_last;
  assign cfg_data  = xfer_act ? s_data : 8'h00;

  pcfg_seq #(
    .REQ_LOW_CYC (REQ_LOW_CYC),
    .ST2CK_CYC   (ST2CK_CYC),
    .DONE_TMO_CYC(DONE_TMO_CYC),
    .INIT_TMO_CYC(INIT_TMO_CYC),
    .TW          (TW)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .tgt_status   (tgt_status),
    .tgt_done     (tgt_done),
    .tgt_init_done(tgt_init_done),
    .last_take    (last_take),
    .tmr_expired  (tmr_expired),
    .tmr_load     (tmr_load),
    .tmr_val      (tmr_val),
    .xfer_act     (xfer_act),
    .xfer_next    (xfer_next),
    .cfg_req_n    (cfg_req_n),
    .busy         (busy),
    .cfg_ok       (cfg_ok),
    .err_status   (err_status),
    .err_timeout  (err_timeout)
  );

  pcfg_timer #(.W(TW)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_expired)
  );

  pcfg_pacer #(.CPB(CLKS_PER_BYTE)) u_pacer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (xfer_next),
    .xfer_act (xfer_act),
    .s_valid  (s_valid),
    .cfg_clk  (cfg_clk),
    .edge_last(edge_last),
    .s_ready  (s_ready)
  );

endmodule

// File: rtl/pcfg_host_chk.sv
module pcfg_host_chk (
  input logic clk,
  input logic rst_n,
  input logic xfer_act,
  input logic cfg_clk,
  input logic cfg_req_n,
  input logic s_valid,
  input logic s_ready,
  input logic tgt_status,
  input logic busy,
  input logic cfg_ok,
  input logic err_status,
  input logic err_timeout
);

  // R10: the configuration clock is only ever high while loading
  p_clk_in_xfer_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clk |-> xfer_act);

  // R5: consumption only during a high phase
  p_ready_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> cfg_clk);

  // R4: a high phase never lasts more than one system clock
  p_high_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clk |=> !cfg_clk);

  // R6: a rising edge only follows a low clock with a byte waiting
  p_rise_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_clk) |-> $past(s_valid));

  // R7: status loss while clocking aborts on the next clock
  p_stat_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_act && !tgt_status) |=> (err_status && !busy && !cfg_clk));

  // R11: result flags are mutually exclusive
  p_flags_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cfg_ok, err_status, err_timeout}));

  // R2: the request is low only inside an active cycle
  p_req_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_req_n |-> busy);

endmodule

bind pcfg_host pcfg_host_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .xfer_act   (xfer_act),
  .cfg_clk    (cfg_clk),
  .cfg_req_n  (cfg_req_n),
  .s_valid    (s_valid),
  .s_ready    (s_ready),
  .tgt_status (tgt_status),
  .busy       (busy),
  .cfg_ok     (cfg_ok),
  .err_status (err_status),
  .err_timeout(err_timeout)
);

// File: tb/tb_pcfg_host.sv
module tb_pcfg_host;

  localparam int CPB  = 4;
  localparam int REQ  = 8;
  localparam int ST2  = 10;
  localparam int DTMO = 200;
  localparam int ITMO = 100;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n   = 1'b0;
  logic       start   = 1'b0;
  logic [7:0] s_data  = 8'h00;
  logic       s_valid = 1'b0;
  logic       s_last  = 1'b0;
  logic       tgt_status = 1'b1;
  logic       tgt_done   = 1'b0;
  logic       tgt_init_done = 1'b0;
  logic       s_ready, cfg_req_n, cfg_clk, busy, cfg_ok, err_status, err_timeout;
  logic [7:0] cfg_data;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int por_len = 6, done_edges = -1, init_lat = 4, drop_at = -1, por = 0, init_cnt = -1;
  int edge_n = 0, first_rise = -1, st_hi = -1, reqlow = 0, hs_cnt = 0, ready_bad = 0;
  logic [7:0] edge_log [0:63];

  pcfg_host #(
    .CLKS_PER_BYTE(CPB), .REQ_LOW_CYC(REQ), .ST2CK_CYC(ST2),
    .DONE_TMO_CYC(DTMO), .INIT_TMO_CYC(ITMO)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .s_data(s_data), .s_valid(s_valid),
    .s_last(s_last), .s_ready(s_ready), .tgt_status(tgt_status), .tgt_done(tgt_done),
    .tgt_init_done(tgt_init_done), .cfg_req_n(cfg_req_n), .cfg_clk(cfg_clk),
    .cfg_data(cfg_data), .busy(busy), .cfg_ok(cfg_ok), .err_status(err_status),
    .err_timeout(err_timeout)
  );

  always @(posedge clk) cyc++;

  // monitor and target model, both at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (cfg_clk) begin
        if (edge_n < 64) edge_log[edge_n] = cfg_data;
        edge_n++;
        if (first_rise < 0) first_rise = cyc;
      end
      if (!cfg_req_n) reqlow++;
      if (s_ready && !cfg_clk) ready_bad++;
      if (s_ready && s_valid) hs_cnt++;

      if (!cfg_req_n) begin
        tgt_status = 1'b0; por = por_len; tgt_done = 1'b0;
        tgt_init_done = 1'b0; init_cnt = -1;
      end else begin
        if (por > 0) begin
          por--;
          if (por == 0) begin tgt_status = 1'b1; st_hi = cyc; end
        end
        if (drop_at >= 0 && edge_n >= drop_at) tgt_status = 1'b0;
        if (done_edges >= 0 && !tgt_done && edge_n >= done_edges) begin
          tgt_done = 1'b1; init_cnt = init_lat;
        end else if (tgt_done && init_cnt > 0) begin
          init_cnt--;
          if (init_cnt == 0) tgt_init_done = 1'b1;
        end
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    if (cyc == 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion earlier", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(input int base, input int i);
    return 8'((base + i * 37) & 255);
  endfunction

  task automatic clr_log();
    edge_n = 0; first_rise = -1; reqlow = 0; hs_cnt = 0; ready_bad = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_idle(input int lim);
    int w = 0;
    while (busy && w < lim) begin @(negedge clk); w++; end
  endtask

  // drive n bytes; optional pause after byte gap_at with a start poke inside it
  task automatic send_stream(input int n, input int base, input int gap_at, input int gap_len);
    for (int i = 0; i < n; i++) begin
      int w = 0;
      @(negedge clk);
      s_valid = 1'b1; s_data = byte_of(base, i); s_last = (i == n - 1);
      while (!s_ready && busy && w < 2000) begin @(negedge clk); w++; end
      if (!s_ready) begin s_valid = 1'b0; s_last = 1'b0; return; end
      @(posedge clk);
      if (i == gap_at) begin
        int e0, r0, hi;
        @(negedge clk);
        s_valid = 1'b0; s_last = 1'b0;
        e0 = edge_n; r0 = reqlow; hi = 0;
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int g = 1; g < gap_len; g++) begin
          @(negedge clk);
          if (cfg_clk) hi++;
        end
        chk(edge_n == e0 && hi == 0, "R6 clock held low while stream idle", edge_n - e0 + hi, 0);
        chk(reqlow == r0 && cfg_req_n, "R2 start ignored while busy", reqlow - r0, 0);
      end
    end
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic chk_bytes(input int n, input int base);
    int bad = 0;
    chk(edge_n == CPB * n, "R4 rising edges per bitstream", edge_n, CPB * n);
    for (int k = 0; k < CPB * n && k < 64; k++)
      if (edge_log[k] !== byte_of(base, k / CPB)) bad++;
    chk(bad == 0, "R4 byte order and hold", bad, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(cfg_req_n && !cfg_clk && !s_ready, "R1 pins after reset",
        {29'd0, cfg_req_n, cfg_clk, s_ready}, 4);
    chk(!busy && !cfg_ok && !err_status && !err_timeout, "R1 flags after reset",
        {28'd0, busy, cfg_ok, err_status, err_timeout}, 0);
  endtask

  task automatic t_normal(input int n, input int base, input int gap_at, input int gap_len);
    int low = 0;
    por_len = 6; done_edges = CPB * n; init_lat = 4; drop_at = -1;
    clr_log();
    pulse_start();
    chk(busy && !cfg_ok && !err_status && !err_timeout, "R11 flags cleared on start",
        {28'd0, busy, cfg_ok, err_status, err_timeout}, 8);
    send_stream(n, base, gap_at, gap_len);
    wait_idle(800);
    chk(reqlow == REQ, "R2 request low width", reqlow, REQ);
    chk(first_rise - st_hi >= ST2 && first_rise - st_hi <= ST2 + 2,
        "R3 status-to-clock delay", first_rise - st_hi, ST2 + 1);
    chk_bytes(n, base);
    chk(hs_cnt == n && ready_bad == 0, "R5 one consumption per byte in high phase",
        hs_cnt * 100 + ready_bad, n * 100);
    chk(cfg_ok && !busy && !err_timeout && !err_status, "R8 user mode reported",
        {28'd0, cfg_ok, busy, err_timeout, err_status}, 8);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (cfg_clk) low++;
    end
    chk(low == 0 && edge_n == CPB * n, "R10 clock parked low after completion", low, 0);
  endtask

  task automatic t_status_drop();
    por_len = 3; done_edges = -1; drop_at = 6;
    clr_log();
    pulse_start();
    send_stream(5, 8'h55, -1, 0);
    wait_idle(400);
    chk(err_status && !cfg_ok && !err_timeout, "R7 status loss flagged",
        {29'd0, err_status, cfg_ok, err_timeout}, 4);
    chk(edge_n == 6 && !cfg_clk && !busy, "R7 clocking stops at once", edge_n, 6);
    drop_at = -1;
  endtask

  task automatic t_done_tmo();
    int t0;
    por_len = 4; done_edges = -1;
    clr_log();
    pulse_start();
    send_stream(2, 8'h30, -1, 0);
    t0 = cyc;
    wait_idle(1000);
    chk(err_timeout && !cfg_ok && !err_status, "R9 done timeout flagged",
        {29'd0, err_timeout, cfg_ok, err_status}, 4);
    chk(cyc - t0 >= DTMO - 1 && cyc - t0 <= DTMO + 2, "R9 done timeout length",
        cyc - t0, DTMO);
  endtask

  task automatic t_init_tmo();
    por_len = 4; done_edges = CPB * 2; init_lat = 1000;
    clr_log();
    pulse_start();
    send_stream(2, 8'h77, -1, 0);
    wait_idle(1000);
    chk(err_timeout && !cfg_ok && tgt_done, "R9 init-done timeout flagged",
        {29'd0, err_timeout, cfg_ok, tgt_done}, 5);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_normal(5, 8'h11, 1, 6);
    t_status_drop();
    t_done_tmo();
    t_init_tmo();
    t_normal(3, 8'hA0, -1, 0);
    summary();
    $finish;
  end

endmodule